// File: doc/BRIEF.md
# SCSI Target Command Screening and Sense Unit

This block sits behind the command phase of a small SCSI target that drives a CAMAC crate system. It receives the command descriptor block one byte per cycle, together with the logical unit number and a bad-bit flag taken from the preceding IDENTIFY message. It decides whether the command may run, keeps the unit-attention condition, and holds the sense information that a later REQUEST SENSE returns. The bus phase machinery and the data movers are outside the block. The phase machinery calls `cmd_begin` before the CDB bytes. The execution engine starts on `dec_go` and later reports its outcome on `exe_done`.

Each command ends with one status byte on `st_vld`/`st_byte`. The status comes at decision time when the command is refused, or when it is TEST UNIT READY. Otherwise it comes when the execution engine finishes. A successful CAMAC command reports its Q response through the status byte: CONDITION MET when Q is 1, GOOD when Q is 0. The 18-byte sense record is read combinationally through `sense_addr`/`sense_dat`. The REQUEST SENSE data mover streams it from there.

Top module: `scsi_cmd_screen`

## Requirements
- R1: The CDB length follows from byte 0. Opcode E1h (CAMAC transfer) has 10 bytes. Opcodes 00h (TEST UNIT READY), 03h (REQUEST SENSE), 12h (INQUIRY) and C1h (CAMAC control) have 6 bytes. Any other opcode is taken as 6 bytes and is refused with status 02h, sense key 5h and ASC 20h.
- R2: A forbidden non-zero bit gives status 02h, key 5h and ASC 24h. Bytes 1 to 5 of TEST UNIT READY must be zero. In REQUEST SENSE and INQUIRY, bytes 1, 2, 3 and 5 must be zero. In C1h, byte 1 bits 7:5 must be zero and bit 3 must be set, byte 2 bits 7:5 and byte 3 bits 7:4 must be zero, and byte 5 must be zero. In E1h, byte 1 must be zero, byte 2 bits 7, 6 and 3 must be zero, byte 4 bit 7 must be zero, and byte 9 must be zero.
- R3: A bad IDENTIFY bit gives key 5h with ASC 3Dh. A non-zero IDENTIFY LUN gives key 5h with ASC 25h, except for INQUIRY, which still runs. The checks are made in this order: 3Dh, 25h, 20h, 24h, then unit attention.
- R4: The status byte takes only three values: 00h for GOOD, 02h for CHECK CONDITION and 04h for CONDITION MET. A C1h or E1h command that finishes without error reports 04h when `exe_q` is 1 and 00h otherwise. Other commands ignore `exe_q`.
- R5: Reset and a pulse on `ua_evt` each set unit attention. While it is set, a TEST UNIT READY or CAMAC command that passes the R1 to R3 checks does not run (`dec_go` is 0). It reports status 02h and leaves sense key 6h with ASC 29h.
- R6: Unit attention is cleared by the single report of R5. The next TEST UNIT READY gives 00h. INQUIRY and REQUEST SENSE run normally under unit attention and leave it pending.
- R7: At its decision, every command except REQUEST SENSE clears the stored sense (key 0, ASC 0, deficit 0) before its own result is recorded. A REQUEST SENSE keeps the sense until it finishes, and then clears it.
- R8: Execution outcome codes on `exe_res` map to sense as follows. Code 1 (no X response) gives key 4h, ASC 44h. Code 2 (parity) gives key 4h, ASC 47h. Code 3 (short stop-mode transfer) gives key 9h, ASC 80h. Each reports status 02h and stores `exe_deficit`. Code 0 is success.
- R9: The sense record has these bytes. Byte 0 is 70h. Byte 2 holds the key in bits 3:0. Bytes 4, 5 and 6 hold the word deficit, most significant byte first. Byte 7 is 08h. Byte 12 is the ASC. All other bytes are 00h, and so is any address at 18 or above.
- R10: `dec_vld` pulses in the cycle right after the last CDB byte is taken. A passing TEST UNIT READY gives status 00h in that same cycle, with `dec_go` at 0. A passing INQUIRY, REQUEST SENSE or CAMAC command raises `dec_go` and gives no status until `exe_done`.
- R11: A `ua_evt` pulse in the same cycle as a unit-attention report leaves unit attention set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets unit attention |
| cmd_begin | input | 1 | Pulse before a new CDB; captures IDENTIFY information |
| ident_lun | input | 3 | LUN from IDENTIFY |
| ident_bad | input | 1 | IDENTIFY carried an illegal bit |
| cdb_vld | input | 1 | CDB byte present |
| cdb_byte | input | 8 | CDB byte, byte 0 first |
| ua_evt | input | 1 | Bus or device reset event |
| dec_vld | output | 1 | Decision pulse |
| dec_go | output | 1 | Command handed to the execution engine |
| exe_done | input | 1 | Execution finished |
| exe_res | input | 2 | Outcome code (R8) |
| exe_q | input | 1 | CAMAC Q of the finished command |
| exe_deficit | input | DEF_W | Words not transferred |
| st_vld | output | 1 | Status byte present |
| st_byte | output | 8 | Status byte |
| sense_addr | input | SADDR_W | Sense record byte address |
| sense_dat | output | 8 | Sense record byte |

## Verification
The embedded assertions check four things on every cycle: the legal status codes, that unit attention always blocks execution, the one-cycle decision timing, and that a `ua_evt` pulse is never lost. A cleared sense record never carries a stale ASC or deficit, and this is also checked on every cycle. Other behaviours appear only across several commands, so only the bench scenarios can show them. These are the single-use nature of unit attention, the clearing rules around REQUEST SENSE, the priority among refusal reasons, and the mapping from an execution outcome to the key, ASC and deficit bytes.

// File: rtl/scsi_screen_pkg.sv
package scsi_screen_pkg;

   localparam logic [7:0] OP_TUR    = 8'h00;
   localparam logic [7:0] OP_RSENSE = 8'h03;
   localparam logic [7:0] OP_INQ    = 8'h12;
   localparam logic [7:0] OP_CAM_ND = 8'hC1;
   localparam logic [7:0] OP_CAM_DT = 8'hE1;

   localparam logic [7:0] ST_GOOD  = 8'h00;
   localparam logic [7:0] ST_CHECK = 8'h02;
   localparam logic [7:0] ST_MET   = 8'h04;

   localparam logic [3:0] KEY_NONE  = 4'h0;
   localparam logic [3:0] KEY_HW    = 4'h4;
   localparam logic [3:0] KEY_ILL   = 4'h5;
   localparam logic [3:0] KEY_UA    = 4'h6;
   localparam logic [3:0] KEY_SHORT = 4'h9;

   localparam logic [7:0] ASC_BAD_OP  = 8'h20;
   localparam logic [7:0] ASC_BAD_FLD = 8'h24;
   localparam logic [7:0] ASC_BAD_LUN = 8'h25;
   localparam logic [7:0] ASC_RESET   = 8'h29;
   localparam logic [7:0] ASC_BAD_ID  = 8'h3D;
   localparam logic [7:0] ASC_NOX     = 8'h44;
   localparam logic [7:0] ASC_PARITY  = 8'h47;
   localparam logic [7:0] ASC_NOQ     = 8'h80;

   typedef enum logic [1:0] {RES_OK, RES_NOX, RES_PARITY, RES_QSHORT} exe_res_t;

   function automatic logic op_known(logic [7:0] op);
      return (op == OP_TUR) || (op == OP_RSENSE) || (op == OP_INQ) ||
             (op == OP_CAM_ND) || (op == OP_CAM_DT);
   endfunction

   function automatic logic [3:0] cdb_len(logic [7:0] op);
      return (op == OP_CAM_DT) ? 4'd10 : 4'd6;
   endfunction

   // bits that must read as zero in byte idx of a CDB with opcode op
   function automatic logic [7:0] zero_mask(logic [7:0] op, logic [3:0] idx);
      logic [7:0] m;
      m = 8'h00;
      case (op)
         OP_TUR:           if (idx != 4'd0) m = 8'hFF;
         OP_RSENSE, OP_INQ:
            if (idx == 4'd1 || idx == 4'd2 || idx == 4'd3 || idx == 4'd5) m = 8'hFF;
         OP_CAM_ND:
            case (idx)
               4'd1, 4'd2: m = 8'hE0;
               4'd3:       m = 8'hF0;
               4'd5:       m = 8'hFF;
               default:    m = 8'h00;
            endcase
         OP_CAM_DT:
            case (idx)
               4'd1:    m = 8'hFF;
               4'd2:    m = 8'hC8;
               4'd4:    m = 8'h80;
               4'd9:    m = 8'hFF;
               default: m = 8'h00;
            endcase
         default: m = 8'h00;
      endcase
      return m;
   endfunction

   // bits that must read as one
   function automatic logic [7:0] one_mask(logic [7:0] op, logic [3:0] idx);
      return (op == OP_CAM_ND && idx == 4'd1) ? 8'h08 : 8'h00;
   endfunction

endpackage

// File: rtl/cdb_field_chk.sv
module cdb_field_chk
   import scsi_screen_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_begin,
   input  logic       byte_vld,
   input  logic [7:0] byte_dat,
   output logic       done_o,
   output logic [7:0] op_o,
   output logic       bad_op_o,
   output logic       bad_fld_o
);

   if (IDX_W < 4) begin : g_idx_too_small
      $error("cdb_field_chk: IDX_W must cover a 10-byte CDB");
   end

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       op_q;
   logic             fld_bad_q;

   logic [7:0] cur_op;
   logic       take;
   logic       byte_bad;
   logic       is_last;
   logic [3:0] idx4;

   assign idx4     = idx_q[3:0];
   assign cur_op   = (idx_q == '0) ? byte_dat : op_q;
   assign take     = byte_vld && active_q;
   assign byte_bad = (|(byte_dat & zero_mask(cur_op, idx4))) ||
                     ((byte_dat & one_mask(cur_op, idx4)) != one_mask(cur_op, idx4));
   assign is_last  = (idx_q == IDX_W'(cdb_len(cur_op) - 4'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         idx_q     <= '0;
         op_q      <= 8'h00;
         fld_bad_q <= 1'b0;
         done_o    <= 1'b0;
         bad_op_o  <= 1'b0;
         bad_fld_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (cmd_begin) begin
            active_q  <= 1'b1;
            idx_q     <= '0;
            fld_bad_q <= 1'b0;
         end else if (take) begin
            op_q      <= cur_op;
            idx_q     <= idx_q + 1'b1;
            fld_bad_q <= fld_bad_q | byte_bad;
            if (is_last) begin
               active_q  <= 1'b0;
               done_o    <= 1'b1;
               bad_op_o  <= !op_known(cur_op);
               bad_fld_o <= fld_bad_q | byte_bad;
            end
         end
      end
   end

   assign op_o = op_q;

endmodule

// File: rtl/sense_store.sv
module sense_store
   import scsi_screen_pkg::*;
#(
   parameter int DEF_W       = 24,
   parameter int SENSE_BYTES = 18,
   parameter int ADDR_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              set_i,
   input  logic [3:0]        key_i,
   input  logic [7:0]        asc_i,
   input  logic [DEF_W-1:0]  def_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_dat_o
);

   localparam int ADD_LEN = SENSE_BYTES - 10;

   if (SENSE_BYTES < 13 || SENSE_BYTES > 32) begin : g_bad_len
      $error("sense_store: SENSE_BYTES out of range");
   end
   if (DEF_W < 1 || DEF_W > 24) begin : g_bad_def
      $error("sense_store: DEF_W must fit three bytes");
   end
   if ((1 << ADDR_W) < SENSE_BYTES) begin : g_bad_addr
      $error("sense_store: ADDR_W too narrow");
   end

   logic [3:0]       key_q;
   logic [7:0]       asc_q;
   logic [DEF_W-1:0] def_q;
   logic [23:0]      def24;
   logic [7:0]       sb [SENSE_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= KEY_NONE;
         asc_q <= 8'h00;
         def_q <= '0;
      end else if (set_i) begin
         key_q <= key_i;
         asc_q <= asc_i;
         def_q <= def_i;
      end else if (clr_i) begin
         key_q <= KEY_NONE;
         asc_q <= 8'h00;
         def_q <= '0;
      end
   end

   if (DEF_W == 24) begin : g_def_full
      assign def24 = def_q;
   end else begin : g_def_pad
      assign def24 = {{(24-DEF_W){1'b0}}, def_q};
   end

   function automatic logic [7:0] byte_at(int i, logic [3:0] k, logic [7:0] a, logic [23:0] d);
      case (i)
         0:       return 8'h70;
         2:       return {4'h0, k};
         4:       return d[23:16];
         5:       return d[15:8];
         6:       return d[7:0];
         7:       return 8'(ADD_LEN);
         12:      return a;
         default: return 8'h00;
      endcase
   endfunction

   for (genvar g = 0; g < SENSE_BYTES; g++) begin : g_byte
      assign sb[g] = byte_at(g, key_q, asc_q, def24);
   end

   assign rd_dat_o = (rd_addr_i < ADDR_W'(SENSE_BYTES)) ? sb[rd_addr_i] : 8'h00;

   AST_CLEAR_IS_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      (key_q == KEY_NONE) |-> (asc_q == 8'h00 && def_q == '0)) else $error("stale sense"); // R7

endmodule

// File: rtl/scsi_cmd_screen.sv
module scsi_cmd_screen
   import scsi_screen_pkg::*;
#(
   parameter int DEF_W       = 24,
   parameter int SENSE_BYTES = 18,
   localparam int SADDR_W    = $clog2(SENSE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_begin,
   input  logic [2:0]         ident_lun,
   input  logic               ident_bad,
   input  logic               cdb_vld,
   input  logic [7:0]         cdb_byte,
   input  logic               ua_evt,
   output logic               dec_vld,
   output logic               dec_go,
   input  logic               exe_done,
   input  logic [1:0]         exe_res,
   input  logic               exe_q,
   input  logic [DEF_W-1:0]   exe_deficit,
   output logic               st_vld,
   output logic [7:0]         st_byte,
   input  logic [SADDR_W-1:0] sense_addr,
   output logic [7:0]         sense_dat
);

   logic       chk_done, chk_bad_op, chk_bad_fld;
   logic [7:0] chk_op;

   cdb_field_chk #(.IDX_W(4)) i_fld (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_begin (cmd_begin),
      .byte_vld  (cdb_vld),
      .byte_dat  (cdb_byte),
      .done_o    (chk_done),
      .op_o      (chk_op),
      .bad_op_o  (chk_bad_op),
      .bad_fld_o (chk_bad_fld)
   );

   logic [2:0] lun_q;
   logic       idbad_q;
   logic       ua_q;
   logic       busy_q;
   logic [7:0] run_op_q;

   logic is_tur, is_cam, is_rs, is_inq, ua_block;
   logic rej;
   logic [3:0] rkey;
   logic [7:0] rasc;

   assign is_tur   = (chk_op == OP_TUR);
   assign is_rs    = (chk_op == OP_RSENSE);
   assign is_inq   = (chk_op == OP_INQ);
   assign is_cam   = (chk_op == OP_CAM_ND) || (chk_op == OP_CAM_DT);
   assign ua_block = ua_q && (is_tur || is_cam);

   always_comb begin
      rej  = 1'b1;
      rkey = KEY_ILL;
      rasc = 8'h00;
      if (idbad_q)                       rasc = ASC_BAD_ID;
      else if (lun_q != 3'd0 && !is_inq) rasc = ASC_BAD_LUN;
      else if (chk_bad_op)               rasc = ASC_BAD_OP;
      else if (chk_bad_fld)              rasc = ASC_BAD_FLD;
      else if (ua_block) begin
         rkey = KEY_UA;
         rasc = ASC_RESET;
      end else                           rej  = 1'b0;
   end

   // completion side
   exe_res_t res;
   logic     fin, fin_err, run_cam;
   logic [3:0] fkey;
   logic [7:0] fasc;

   assign res     = exe_res_t'(exe_res);
   assign fin     = exe_done && busy_q;
   assign fin_err = (res != RES_OK);
   assign run_cam = (run_op_q == OP_CAM_ND) || (run_op_q == OP_CAM_DT);

   always_comb begin
      case (res)
         RES_NOX:    begin fkey = KEY_HW;    fasc = ASC_NOX;    end
         RES_PARITY: begin fkey = KEY_HW;    fasc = ASC_PARITY; end
         RES_QSHORT: begin fkey = KEY_SHORT; fasc = ASC_NOQ;    end
         default:    begin fkey = KEY_NONE;  fasc = 8'h00;      end
      endcase
   end

   assign dec_vld = chk_done;
   assign dec_go  = chk_done && !rej && !is_tur;
   assign st_vld  = (chk_done && (rej || is_tur)) || fin;

   always_comb begin
      if (chk_done)          st_byte = rej ? ST_CHECK : ST_GOOD;
      else if (fin_err)      st_byte = ST_CHECK;
      else if (run_cam && exe_q) st_byte = ST_MET;
      else                   st_byte = ST_GOOD;
   end

   // sense control
   logic             s_clr, s_set;
   logic [3:0]       s_key;
   logic [7:0]       s_asc;
   logic [DEF_W-1:0] s_def;

   assign s_clr = (chk_done && !is_rs) || (fin && run_op_q == OP_RSENSE);
   assign s_set = (chk_done && rej) || (fin && fin_err);
   assign s_key = chk_done ? rkey : fkey;
   assign s_asc = chk_done ? rasc : fasc;
   assign s_def = chk_done ? '0 : exe_deficit;

   sense_store #(.DEF_W(DEF_W), .SENSE_BYTES(SENSE_BYTES), .ADDR_W(SADDR_W)) i_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (s_clr),
      .set_i     (s_set),
      .key_i     (s_key),
      .asc_i     (s_asc),
      .def_i     (s_def),
      .rd_addr_i (sense_addr),
      .rd_dat_o  (sense_dat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lun_q    <= 3'd0;
         idbad_q  <= 1'b0;
         ua_q     <= 1'b1;
         busy_q   <= 1'b0;
         run_op_q <= 8'h00;
      end else begin
         if (cmd_begin) begin
            lun_q   <= ident_lun;
            idbad_q <= ident_bad;
         end
         if (ua_evt)
            ua_q <= 1'b1;
         else if (chk_done && rej && rkey == KEY_UA)
            ua_q <= 1'b0;
         if (dec_go) begin
            busy_q   <= 1'b1;
            run_op_q <= chk_op;
         end else if (fin) begin
            busy_q <= 1'b0;
         end
      end
   end

   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld |-> (st_byte == ST_GOOD || st_byte == ST_CHECK || st_byte == ST_MET)) else $error("bad status"); // R4
   AST_UA_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && ua_q && (is_tur || is_cam)) |-> !dec_go) else $error("ran under UA"); // R5
   AST_DECIDE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(cdb_vld)) else $error("late decision"); // R10
   AST_GO_DEFERS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_go |-> !st_vld) else $error("early status"); // R10
   AST_UA_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ua_evt |=> ua_q) else $error("UA lost"); // R11

endmodule

// File: tb/test_scsi_cmd_screen.sv
module test_scsi_cmd_screen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_begin = 1'b0;
   logic [2:0] ident_lun = 3'd0;
   logic       ident_bad = 1'b0;
   logic       cdb_vld = 1'b0;
   logic [7:0] cdb_byte = 8'h00;
   logic       ua_evt = 1'b0;
   logic       dec_vld, dec_go;
   logic       exe_done = 1'b0;
   logic [1:0] exe_res = 2'd0;
   logic       exe_q = 1'b0;
   logic [23:0] exe_deficit = 24'd0;
   logic       st_vld;
   logic [7:0] st_byte;
   logic [4:0] sense_addr = 5'd0;
   logic [7:0] sense_dat;

   always #4 clk = ~clk;

   scsi_cmd_screen i_scsi_cmd_screen (
      .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .ident_lun(ident_lun),
      .ident_bad(ident_bad), .cdb_vld(cdb_vld), .cdb_byte(cdb_byte), .ua_evt(ua_evt),
      .dec_vld(dec_vld), .dec_go(dec_go), .exe_done(exe_done), .exe_res(exe_res),
      .exe_q(exe_q), .exe_deficit(exe_deficit), .st_vld(st_vld), .st_byte(st_byte),
      .sense_addr(sense_addr), .sense_dat(sense_dat)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [7:0] exp_st [$];
   string      exp_tag [$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (st_vld) begin
            if (exp_st.size() == 0) begin
               check(1'b0, "unexpected status", int'(st_byte), 0);
            end else begin
               automatic logic [7:0] e = exp_st.pop_front();
               automatic string t = exp_tag.pop_front();
               check(st_byte == e, t, int'(st_byte), int'(e));
            end
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      check(1'b0, "watchdog", 0, 1);
      summary();
   end

   task automatic run_cmd(input logic [2:0] lun, input bit ibad, input logic [79:0] b,
                          input int n, input bit exp_go, input logic [7:0] exp_s,
                          input bit evt_at_dec, input string req);
      if (!exp_go) begin
         exp_st.push_back(exp_s);
         exp_tag.push_back(req);
      end
      @(negedge clk);
      cmd_begin = 1'b1; ident_lun = lun; ident_bad = ibad;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_begin = 1'b0;
         cdb_vld = 1'b1;
         cdb_byte = b[79-8*i -: 8];
         if (i == n - 1) begin
            #2;
            check(dec_vld == 1'b0, {req, " R10 no early decision"}, int'(dec_vld), 0);
         end
      end
      @(negedge clk);
      cdb_vld = 1'b0;
      ua_evt = evt_at_dec;
      #2;
      check(dec_vld == 1'b1, {req, " R10 decision timing"}, int'(dec_vld), 1);
      check(dec_go == exp_go, {req, " go"}, int'(dec_go), int'(exp_go));
      if (evt_at_dec) begin
         @(negedge clk);
         ua_evt = 1'b0;
      end
   endtask

   task automatic finish_cmd(input logic [1:0] res, input bit q, input logic [23:0] def,
                             input logic [7:0] exp_s, input string req);
      exp_st.push_back(exp_s);
      exp_tag.push_back(req);
      @(negedge clk);
      exe_done = 1'b1; exe_res = res; exe_q = q; exe_deficit = def;
      @(negedge clk);
      exe_done = 1'b0; exe_res = 2'd0; exe_q = 1'b0; exe_deficit = 24'd0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      sense_addr = a;
      #2;
      d = sense_dat;
   endtask

   task automatic chk_sense(input logic [3:0] key, input logic [7:0] asc,
                            input logic [23:0] def, input string req);
      logic [7:0] d;
      rd(5'd2, d);  check(d == {4'h0, key}, {req, " key"}, int'(d), int'(key));
      rd(5'd12, d); check(d == asc, {req, " asc"}, int'(d), int'(asc));
      rd(5'd4, d);  check(d == def[23:16], {req, " deficit hi"}, int'(d), int'(def[23:16]));
      rd(5'd5, d);  check(d == def[15:8], {req, " deficit mid"}, int'(d), int'(def[15:8]));
      rd(5'd6, d);  check(d == def[7:0], {req, " deficit lo"}, int'(d), int'(def[7:0]));
   endtask

   task automatic pulse_ua();
      @(negedge clk); ua_evt = 1'b1;
      @(negedge clk); ua_evt = 1'b0;
   endtask

   localparam logic [79:0] C_TUR     = 80'h0000_0000_0000_0000_0000;
   localparam logic [79:0] C_TUR_BAD = 80'h0000_0000_0001_0000_0000;
   localparam logic [79:0] C_RS      = 80'h0300_0000_1200_0000_0000;
   localparam logic [79:0] C_INQ     = 80'h1200_0000_2400_0000_0000;
   localparam logic [79:0] C_CND     = 80'hC108_0502_8100_0000_0000;
   localparam logic [79:0] C_CND_BAD = 80'hC100_0502_8100_0000_0000;
   localparam logic [79:0] C_CDT     = 80'hE100_1005_0280_0000_4000;
   localparam logic [79:0] C_CDT_BAD = 80'hE100_9005_0280_0000_4000;
   localparam logic [79:0] C_UNK     = 80'h0800_0000_0000_0000_0000;

   initial begin
      logic [7:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #2;
      check(dec_vld == 1'b0, "reset dec_vld", int'(dec_vld), 0);
      check(st_vld == 1'b0, "reset st_vld", int'(st_vld), 0);
      rd(5'd0, d); check(d == 8'h70, "R9 reset byte0", int'(d), 'h70);
      rd(5'd7, d); check(d == 8'h08, "R9 reset byte7", int'(d), 8);
      chk_sense(4'h0, 8'h00, 24'd0, "reset sense");

      // unit attention from reset
      run_cmd(3'd0, 1'b0, C_TUR, 6, 1'b0, 8'h02, 1'b0, "R5 TUR under UA");
      chk_sense(4'h6, 8'h29, 24'd0, "R5 UA sense");
      run_cmd(3'd0, 1'b0, C_TUR, 6, 1'b0, 8'h00, 1'b0, "R6 TUR after UA report");
      chk_sense(4'h0, 8'h00, 24'd0, "R7 cleared by TUR");

      // INQUIRY and REQUEST SENSE neither blocked nor consuming
      pulse_ua();
      run_cmd(3'd0, 1'b0, C_INQ, 6, 1'b1, 8'h00, 1'b0, "R6 INQ under UA");
      finish_cmd(2'd0, 1'b1, 24'd0, 8'h00, "R4 INQ ignores q");
      run_cmd(3'd0, 1'b0, C_RS, 6, 1'b1, 8'h00, 1'b0, "R6 RS under UA");
      finish_cmd(2'd0, 1'b0, 24'd0, 8'h00, "R6 RS done");
      run_cmd(3'd0, 1'b0, C_TUR, 6, 1'b0, 8'h02, 1'b0, "R6 UA still pending");
      run_cmd(3'd0, 1'b0, C_RS, 6, 1'b1, 8'h00, 1'b0, "R7 RS go");
      chk_sense(4'h6, 8'h29, 24'd0, "R7 RS keeps sense at decision");
      finish_cmd(2'd0, 1'b0, 24'd0, 8'h00, "R7 RS done");
      chk_sense(4'h0, 8'h00, 24'd0, "R7 RS clears on completion");

      // opcodes and lengths
      run_cmd(3'd0, 1'b0, C_UNK, 6, 1'b0, 8'h02, 1'b0, "R1 unknown opcode");
      chk_sense(4'h5, 8'h20, 24'd0, "R1 unknown opcode sense");
      run_cmd(3'd0, 1'b0, C_CND, 6, 1'b1, 8'h00, 1'b0, "R1 C1 go");
      finish_cmd(2'd0, 1'b1, 24'd0, 8'h04, "R4 C1 Q=1");
      run_cmd(3'd0, 1'b0, C_CND, 6, 1'b1, 8'h00, 1'b0, "R1 C1 go again");
      finish_cmd(2'd0, 1'b0, 24'd0, 8'h00, "R4 C1 Q=0");
      run_cmd(3'd0, 1'b0, C_CDT, 10, 1'b1, 8'h00, 1'b0, "R1 E1 ten bytes");
      finish_cmd(2'd0, 1'b1, 24'd0, 8'h04, "R4 E1 Q=1");

      // field checks
      run_cmd(3'd0, 1'b0, C_TUR_BAD, 6, 1'b0, 8'h02, 1'b0, "R2 TUR byte5");
      chk_sense(4'h5, 8'h24, 24'd0, "R2 TUR field sense");
      run_cmd(3'd0, 1'b0, C_CND_BAD, 6, 1'b0, 8'h02, 1'b0, "R2 C1 missing bit3");
      chk_sense(4'h5, 8'h24, 24'd0, "R2 C1 field sense");
      run_cmd(3'd0, 1'b0, C_CDT_BAD, 10, 1'b0, 8'h02, 1'b0, "R2 E1 byte2 bit7");
      chk_sense(4'h5, 8'h24, 24'd0, "R2 E1 field sense");

      // IDENTIFY checks and priority
      run_cmd(3'd1, 1'b0, C_TUR, 6, 1'b0, 8'h02, 1'b0, "R3 TUR lun1");
      chk_sense(4'h5, 8'h25, 24'd0, "R3 lun sense");
      run_cmd(3'd1, 1'b0, C_INQ, 6, 1'b1, 8'h00, 1'b0, "R3 INQ lun1 runs");
      finish_cmd(2'd0, 1'b0, 24'd0, 8'h00, "R3 INQ lun1 done");
      run_cmd(3'd1, 1'b1, C_UNK, 6, 1'b0, 8'h02, 1'b0, "R3 bad identify first");
      chk_sense(4'h5, 8'h3D, 24'd0, "R3 identify priority");
      run_cmd(3'd1, 1'b0, C_UNK, 6, 1'b0, 8'h02, 1'b0, "R3 lun before opcode");
      chk_sense(4'h5, 8'h25, 24'd0, "R3 lun priority");

      // execution errors
      run_cmd(3'd0, 1'b0, C_CND, 6, 1'b1, 8'h00, 1'b0, "R8 C1 go");
      finish_cmd(2'd1, 1'b1, 24'h000001, 8'h02, "R8 no X");
      chk_sense(4'h4, 8'h44, 24'h000001, "R8 no X sense");
      run_cmd(3'd0, 1'b0, C_CDT, 10, 1'b1, 8'h00, 1'b0, "R8 E1 go");
      finish_cmd(2'd2, 1'b0, 24'h000123, 8'h02, "R8 parity");
      chk_sense(4'h4, 8'h47, 24'h000123, "R8 parity sense");
      run_cmd(3'd0, 1'b0, C_CDT, 10, 1'b1, 8'h00, 1'b0, "R8 E1 go again");
      finish_cmd(2'd3, 1'b0, 24'h0A0B0C, 8'h02, "R8 short transfer");
      chk_sense(4'h9, 8'h80, 24'h0A0B0C, "R8 short sense");
      rd(5'd0, d);  check(d == 8'h70, "R9 byte0", int'(d), 'h70);
      rd(5'd1, d);  check(d == 8'h00, "R9 byte1", int'(d), 0);
      rd(5'd7, d);  check(d == 8'h08, "R9 byte7", int'(d), 8);
      rd(5'd17, d); check(d == 8'h00, "R9 byte17", int'(d), 0);
      rd(5'd31, d); check(d == 8'h00, "R9 out of range", int'(d), 0);

      // new command clears before evaluation
      run_cmd(3'd0, 1'b0, C_INQ, 6, 1'b1, 8'h00, 1'b0, "R7 INQ go");
      chk_sense(4'h0, 8'h00, 24'd0, "R7 cleared at INQ decision");
      finish_cmd(2'd0, 1'b0, 24'd0, 8'h00, "R7 INQ done");

      // CAMAC under UA
      pulse_ua();
      run_cmd(3'd0, 1'b0, C_CND, 6, 1'b0, 8'h02, 1'b0, "R5 C1 under UA");
      chk_sense(4'h6, 8'h29, 24'd0, "R5 C1 UA sense");

      // event coinciding with consumption
      pulse_ua();
      run_cmd(3'd0, 1'b0, C_TUR, 6, 1'b0, 8'h02, 1'b1, "R11 TUR with event");
      run_cmd(3'd0, 1'b0, C_TUR, 6, 1'b0, 8'h02, 1'b0, "R11 UA kept");
      run_cmd(3'd0, 1'b0, C_TUR, 6, 1'b0, 8'h00, 1'b0, "R6 UA gone");

      repeat (4) @(negedge clk);
      check(exp_st.size() == 0, "missing status", exp_st.size(), 0);
      summary();
   end

endmodule